// File: doc/BRIEF.md
# Bus Master Request Eligibility Arbiter

This block decides which pending initiator request goes out next on a parallel bus. It considers three candidates. The first is a continuation of a command that the target cut short. The second is a new read taken from a read queue that other requests may bypass. The third is the write command at the head of the command/write-data buffer. A candidate takes part only when it is eligible. A write is eligible when enough write data is buffered. A read is eligible when a read-response buffer can hold its data. A fixed priority then picks one grant among the eligible candidates, and only while the bus-master engine reports idle.

The block also reacts to how the running transaction ended. A disconnect or retry turns the unfinished part into a pending continuation, which keeps the remaining data-phase count and, for reads, the response buffer it already owns. A target-abort or master-abort on a read sets a sticky read-failure status bit. It also completes the local read with a dummy-data pulse and frees that read's response buffer, so that the next operation proceeds normally. Bus protocol timing, FIFO storage and the local slave logic sit outside the block and appear only as status inputs.

Top module: `bm_elig_arb`

## Requirements
- R1: Grant bits are gnt_o[0] continuation, gnt_o[1] new read, gnt_o[2] new write. When several candidates are eligible, the continuation wins over the read and the read wins over the write. gnt_cnt_o carries the winner's data-phase count: the remaining count for a continuation, rd_burst_i for a read, wr_burst_i for a write.
- R2: gnt_o has at most one bit set, and is all-zero while eng_idle_i is low or when no candidate is eligible.
- R3: A new write is eligible only if wr_vld_i is high and wr_fill_i is at least 8, or at least wr_burst_i.
- R4: A new read is eligible only if one of the two response buffers is free. The lowest free index is given on gnt_rrb_o and shows as busy in rrb_busy_o (bit i = buffer i) from the next cycle on.
- R5: A pulse on rsp_done_i frees buffer rsp_rrb_i from the next cycle on, and a waiting read may then take it.
- R6: A termination with term_kind_i 1 (disconnect) or 2 (retry) creates a pending continuation. It carries term_remain_i and, for a read, the buffer the read already owns. A continuation read is eligible even when no buffer is free.
- R7: A write continuation is eligible only when wr_fill_i is at least 8 or at least its remaining count.
- R8: While a continuation is pending, no new read or new write is granted.
- R9: A termination with term_kind_i 3 (target-abort) or 4 (master-abort) on a read has three effects in the next cycle: rd_fail_o is high, dummy_o pulses for one cycle with dummy_rrb_o naming the read's buffer, and that buffer is free.
- R10: rd_fail_o is sticky and clears only on a cycle with sts_w1c_i high. When a new failure and the clear fall in the same cycle, the bit stays set.
- R11: An abort on a write sets no failure bit and gives no dummy pulse, and the next eligible command is granted normally.
- R12: A termination with term_kind_i 0 (complete) creates no continuation, and a read's buffer stays busy until rsp_done_i frees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eng_idle_i | input | 1 | Bus-master engine is idle and can take a grant |
| rd_req_i | input | 1 | A new read is waiting in the read queue |
| rd_burst_i | input | CNT_W | Data-phase count of the new read |
| wr_vld_i | input | 1 | Head-of-line write command is present |
| wr_burst_i | input | CNT_W | Data-phase count of the head write |
| wr_fill_i | input | FILL_W | Data phases held in the write-data buffer |
| term_vld_i | input | 1 | The current transaction has ended |
| term_kind_i | input | 3 | 0 complete, 1 disconnect, 2 retry, 3 target-abort, 4 master-abort |
| term_remain_i | input | CNT_W | Data phases left when the transaction ended |
| rsp_done_i | input | 1 | Response fully returned for one buffer |
| rsp_rrb_i | input | IDX_W | Buffer index being freed |
| sts_w1c_i | input | 1 | Write-one-to-clear of the read-failure bit |
| gnt_o | output | 3 | One-hot grant: continuation, read, write |
| gnt_rrb_o | output | IDX_W | Response buffer tied to a read grant |
| gnt_cnt_o | output | CNT_W | Data-phase count of the granted command |
| rrb_busy_o | output | NUM_RRB | Response buffers in use |
| rd_fail_o | output | 1 | Sticky read-failure status |
| dummy_o | output | 1 | Dummy-data completion pulse for a failed read |
| dummy_rrb_o | output | IDX_W | Buffer of the failed read |

## Verification
The bench targets the fill threshold from both sides. It checks fill one below the burst, equal to the burst, and eight against longer bursts. A comparison that is off by one or that drops the eight-phase rule would grant a write early or hold it forever. It fills both response buffers and then shows that a read stalls while a write still goes, and that a continuation read still wins. A design that checked the free map for continuations, or that did not mask new requests while a continuation waits, would deadlock or reorder the command. The failure bit is set and cleared in the same cycle to confirm that the set wins. Write aborts are checked to show they leave the status bit and the dummy pulse untouched.

// File: rtl/bm_arb_pkg.sv
package bm_arb_pkg;
  typedef enum logic [2:0] {
    TERM_DONE   = 3'd0,
    TERM_DISC   = 3'd1,
    TERM_RETRY  = 3'd2,
    TERM_TABORT = 3'd3,
    TERM_MABORT = 3'd4
  } term_kind_e;

  localparam int SRC_CONT = 0;
  localparam int SRC_RD   = 1;
  localparam int SRC_WR   = 2;
  localparam int NUM_SRC  = 3;
endpackage

// File: rtl/bm_rrb_map.sv
module bm_rrb_map #(
  parameter int NUM_RRB = 2,
  parameter int IDX_W   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic               rel_a_i,
  input  logic [IDX_W-1:0]   rel_a_idx_i,
  input  logic               rel_b_i,
  input  logic [IDX_W-1:0]   rel_b_idx_i,
  output logic [NUM_RRB-1:0] busy_o,
  output logic               any_free_o,
  output logic [IDX_W-1:0]   free_idx_o
);
  logic [NUM_RRB-1:0] busy_q, busy_d;

  // lowest free index wins
  always_comb begin
    free_idx_o = '0;
    any_free_o = 1'b0;
    for (int i = NUM_RRB - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        free_idx_o = IDX_W'(i);
        any_free_o = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_RRB; g++) begin : g_bit
    logic clr_a, clr_b, set_b;
    assign clr_a = rel_a_i && (rel_a_idx_i == IDX_W'(g));
    assign clr_b = rel_b_i && (rel_b_idx_i == IDX_W'(g));
    assign set_b = alloc_i && any_free_o && (free_idx_o == IDX_W'(g));
    assign busy_d[g] = (busy_q[g] && !clr_a && !clr_b) || set_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_d;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/bm_elig_eval.sv
module bm_elig_eval
  import bm_arb_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int FILL_W      = 8,
  parameter int FULL_PHASES = 8
) (
  input  logic              cont_vld_i,
  input  logic              cont_is_rd_i,
  input  logic [CNT_W-1:0]  cont_cnt_i,
  input  logic              rd_req_i,
  input  logic              any_free_i,
  input  logic              wr_vld_i,
  input  logic [FILL_W-1:0] wr_fill_i,
  input  logic [CNT_W-1:0]  wr_burst_i,
  output logic [NUM_SRC-1:0] elig_o
);
  localparam int CMP_W = ((CNT_W > FILL_W) ? CNT_W : FILL_W) + 1;
  localparam logic [CMP_W-1:0] FULL_C = CMP_W'(FULL_PHASES);

  logic [CMP_W-1:0] fill_x, wr_need_x, cont_need_x;
  logic             wr_data_ok, cont_data_ok;

  assign fill_x      = CMP_W'(wr_fill_i);
  assign wr_need_x   = CMP_W'(wr_burst_i);
  assign cont_need_x = CMP_W'(cont_cnt_i);

  assign wr_data_ok   = (fill_x >= FULL_C) || (fill_x >= wr_need_x);
  assign cont_data_ok = (fill_x >= FULL_C) || (fill_x >= cont_need_x);

  // a pending continuation holds back new commands to keep order
  always_comb begin
    elig_o           = '0;
    elig_o[SRC_CONT] = cont_vld_i && (cont_is_rd_i || cont_data_ok);
    elig_o[SRC_RD]   = !cont_vld_i && rd_req_i && any_free_i;
    elig_o[SRC_WR]   = !cont_vld_i && wr_vld_i && wr_data_ok;
  end
endmodule

// File: rtl/bm_term_ctl.sv
module bm_term_ctl
  import bm_arb_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int IDX_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gnt_fire_i,
  input  logic             gnt_cont_i,
  input  logic             gnt_is_rd_i,
  input  logic [IDX_W-1:0] gnt_rrb_i,
  input  logic             term_vld_i,
  input  logic [2:0]       term_kind_i,
  input  logic [CNT_W-1:0] term_remain_i,
  input  logic             sts_w1c_i,
  output logic             cont_vld_o,
  output logic             cont_is_rd_o,
  output logic [CNT_W-1:0] cont_cnt_o,
  output logic [IDX_W-1:0] cont_rrb_o,
  output logic             rel_o,
  output logic [IDX_W-1:0] rel_idx_o,
  output logic             rd_fail_o,
  output logic             dummy_o,
  output logic [IDX_W-1:0] dummy_rrb_o
);
  term_kind_e       kind;
  logic             cur_is_rd_q;
  logic [IDX_W-1:0] cur_rrb_q;
  logic             is_split, is_abort, rd_abort;
  logic             cont_vld_q, cont_is_rd_q;
  logic [CNT_W-1:0] cont_cnt_q;
  logic [IDX_W-1:0] cont_rrb_q;
  logic             fail_q, dummy_q;
  logic [IDX_W-1:0] dummy_rrb_q;

  assign kind     = term_kind_e'(term_kind_i);
  assign is_split = term_vld_i && (kind == TERM_DISC || kind == TERM_RETRY);
  assign is_abort = term_vld_i && (kind == TERM_TABORT || kind == TERM_MABORT);
  assign rd_abort = is_abort && cur_is_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_is_rd_q <= 1'b0;
      cur_rrb_q   <= '0;
    end else if (gnt_fire_i) begin
      cur_is_rd_q <= gnt_is_rd_i;
      cur_rrb_q   <= gnt_rrb_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_vld_q   <= 1'b0;
      cont_is_rd_q <= 1'b0;
      cont_cnt_q   <= '0;
      cont_rrb_q   <= '0;
    end else if (is_split) begin
      cont_vld_q   <= 1'b1;
      cont_is_rd_q <= cur_is_rd_q;
      cont_cnt_q   <= term_remain_i;
      cont_rrb_q   <= cur_rrb_q;
    end else if (gnt_cont_i) begin
      cont_vld_q   <= 1'b0;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q      <= 1'b0;
      dummy_q     <= 1'b0;
      dummy_rrb_q <= '0;
    end else begin
      fail_q  <= rd_abort || (fail_q && !sts_w1c_i);
      dummy_q <= rd_abort;
      if (rd_abort) dummy_rrb_q <= cur_rrb_q;
    end
  end

  assign cont_vld_o   = cont_vld_q;
  assign cont_is_rd_o = cont_is_rd_q;
  assign cont_cnt_o   = cont_cnt_q;
  assign cont_rrb_o   = cont_rrb_q;
  assign rel_o        = rd_abort;
  assign rel_idx_o    = cur_rrb_q;
  assign rd_fail_o    = fail_q;
  assign dummy_o      = dummy_q;
  assign dummy_rrb_o  = dummy_rrb_q;
endmodule

// File: rtl/bm_elig_arb.sv
module bm_elig_arb
  import bm_arb_pkg::*;
#(
  parameter int NUM_RRB     = 2,
  parameter int CNT_W       = 8,
  parameter int FILL_W      = 8,
  parameter int FULL_PHASES = 8,
  localparam int IDX_W      = (NUM_RRB > 1) ? $clog2(NUM_RRB) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               eng_idle_i,
  input  logic               rd_req_i,
  input  logic [CNT_W-1:0]   rd_burst_i,
  input  logic               wr_vld_i,
  input  logic [CNT_W-1:0]   wr_burst_i,
  input  logic [FILL_W-1:0]  wr_fill_i,
  input  logic               term_vld_i,
  input  logic [2:0]         term_kind_i,
  input  logic [CNT_W-1:0]   term_remain_i,
  input  logic               rsp_done_i,
  input  logic [IDX_W-1:0]   rsp_rrb_i,
  input  logic               sts_w1c_i,
  output logic [2:0]         gnt_o,
  output logic [IDX_W-1:0]   gnt_rrb_o,
  output logic [CNT_W-1:0]   gnt_cnt_o,
  output logic [NUM_RRB-1:0] rrb_busy_o,
  output logic               rd_fail_o,
  output logic               dummy_o,
  output logic [IDX_W-1:0]   dummy_rrb_o
);
  logic [NUM_SRC-1:0] elig, gnt;
  logic               any_free;
  logic [IDX_W-1:0]   free_idx;
  logic               cont_vld, cont_is_rd;
  logic [CNT_W-1:0]   cont_cnt;
  logic [IDX_W-1:0]   cont_rrb;
  logic               abort_rel;
  logic [IDX_W-1:0]   abort_idx;
  logic               gnt_is_rd;

  bm_rrb_map #(.NUM_RRB(NUM_RRB), .IDX_W(IDX_W)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (gnt[SRC_RD]),
    .rel_a_i     (rsp_done_i),
    .rel_a_idx_i (rsp_rrb_i),
    .rel_b_i     (abort_rel),
    .rel_b_idx_i (abort_idx),
    .busy_o      (rrb_busy_o),
    .any_free_o  (any_free),
    .free_idx_o  (free_idx)
  );

  bm_elig_eval #(.CNT_W(CNT_W), .FILL_W(FILL_W), .FULL_PHASES(FULL_PHASES)) u_elig (
    .cont_vld_i   (cont_vld),
    .cont_is_rd_i (cont_is_rd),
    .cont_cnt_i   (cont_cnt),
    .rd_req_i     (rd_req_i),
    .any_free_i   (any_free),
    .wr_vld_i     (wr_vld_i),
    .wr_fill_i    (wr_fill_i),
    .wr_burst_i   (wr_burst_i),
    .elig_o       (elig)
  );

  // fixed priority: lowest source index first
  always_comb begin
    gnt = '0;
    if (eng_idle_i) begin
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (elig[i]) gnt = NUM_SRC'(1) << i;
      end
    end
  end

  always_comb begin
    gnt_rrb_o = gnt[SRC_CONT] ? cont_rrb : free_idx;
    if (gnt[SRC_CONT])    gnt_cnt_o = cont_cnt;
    else if (gnt[SRC_RD]) gnt_cnt_o = rd_burst_i;
    else                  gnt_cnt_o = wr_burst_i;
  end

  assign gnt_is_rd = gnt[SRC_RD] || (gnt[SRC_CONT] && cont_is_rd);
  assign gnt_o     = gnt;

  bm_term_ctl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_term (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .gnt_fire_i    (|gnt),
    .gnt_cont_i    (gnt[SRC_CONT]),
    .gnt_is_rd_i   (gnt_is_rd),
    .gnt_rrb_i     (gnt_rrb_o),
    .term_vld_i    (term_vld_i),
    .term_kind_i   (term_kind_i),
    .term_remain_i (term_remain_i),
    .sts_w1c_i     (sts_w1c_i),
    .cont_vld_o    (cont_vld),
    .cont_is_rd_o  (cont_is_rd),
    .cont_cnt_o    (cont_cnt),
    .cont_rrb_o    (cont_rrb),
    .rel_o         (abort_rel),
    .rel_idx_o     (abort_idx),
    .rd_fail_o     (rd_fail_o),
    .dummy_o       (dummy_o),
    .dummy_rrb_o   (dummy_rrb_o)
  );
endmodule

// File: rtl/bm_elig_arb_chk.sv
module bm_elig_arb_chk #(
  parameter int NUM_RRB     = 2,
  parameter int CNT_W       = 8,
  parameter int FILL_W      = 8,
  parameter int FULL_PHASES = 8,
  parameter int IDX_W       = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               eng_idle_i,
  input logic [CNT_W-1:0]   wr_burst_i,
  input logic [FILL_W-1:0]  wr_fill_i,
  input logic               sts_w1c_i,
  input logic [2:0]         gnt_i,
  input logic [IDX_W-1:0]   gnt_rrb_i,
  input logic [NUM_RRB-1:0] rrb_busy_i,
  input logic               rd_fail_i,
  input logic               dummy_i,
  input logic               cont_vld_i
);
  // R2
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));

  // R2
  gnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_i) |-> eng_idle_i);

  // R3
  wr_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i[2] |-> ((32'(wr_fill_i) >= FULL_PHASES) || (32'(wr_fill_i) >= 32'(wr_burst_i))));

  // R4
  rd_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i[1] |-> !rrb_busy_i[gnt_rrb_i]);

  // R4
  rd_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_i[1] |=> rrb_busy_i[$past(gnt_rrb_i)]);

  // R8
  cont_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i[1] || gnt_i[2]) |-> !cont_vld_i);

  // R9
  dummy_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_i |-> rd_fail_i);

  // R10
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fail_i && !sts_w1c_i) |=> rd_fail_i);
endmodule

bind bm_elig_arb bm_elig_arb_chk #(
  .NUM_RRB(NUM_RRB), .CNT_W(CNT_W), .FILL_W(FILL_W),
  .FULL_PHASES(FULL_PHASES), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .eng_idle_i (eng_idle_i),
  .wr_burst_i (wr_burst_i),
  .wr_fill_i  (wr_fill_i),
  .sts_w1c_i  (sts_w1c_i),
  .gnt_i      (gnt_o),
  .gnt_rrb_i  (gnt_rrb_o),
  .rrb_busy_i (rrb_busy_o),
  .rd_fail_i  (rd_fail_o),
  .dummy_i    (dummy_o),
  .cont_vld_i (cont_vld)
);

// File: tb/sim_bm_elig_arb.sv
`timescale 1ns/1ps
module sim_bm_elig_arb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       eng_idle_i = 1'b0, rd_req_i = 1'b0, wr_vld_i = 1'b0;
  logic [7:0] rd_burst_i = '0, wr_burst_i = '0, wr_fill_i = '0;
  logic       term_vld_i = 1'b0;
  logic [2:0] term_kind_i = '0;
  logic [7:0] term_remain_i = '0;
  logic       rsp_done_i = 1'b0, rsp_rrb_i = 1'b0, sts_w1c_i = 1'b0;
  logic [2:0] gnt_o;
  logic       gnt_rrb_o;
  logic [7:0] gnt_cnt_o;
  logic [1:0] rrb_busy_o;
  logic       rd_fail_o, dummy_o, dummy_rrb_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bm_elig_arb u0 (.*);

  // {idle, rd, wv, fill[8], burst[8], exp_gnt[3]}
  localparam int NV = 9;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 8'd0, 8'd4,  3'b000},
    {1'b1, 1'b0, 1'b1, 8'd3, 8'd4,  3'b000},
    {1'b1, 1'b0, 1'b1, 8'd4, 8'd4,  3'b100},
    {1'b1, 1'b0, 1'b1, 8'd8, 8'd16, 3'b100},
    {1'b1, 1'b0, 1'b1, 8'd7, 8'd16, 3'b000},
    {1'b1, 1'b1, 1'b1, 8'd8, 8'd8,  3'b010},
    {1'b1, 1'b1, 1'b0, 8'd0, 8'd0,  3'b010},
    {1'b0, 1'b1, 1'b1, 8'd8, 8'd8,  3'b000},
    {1'b1, 1'b0, 1'b1, 8'd9, 8'd16, 3'b100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_in();
    eng_idle_i = 0; rd_req_i = 0; wr_vld_i = 0; wr_fill_i = 0; wr_burst_i = 0;
    rd_burst_i = 0; term_vld_i = 0; term_kind_i = 0; term_remain_i = 0;
    rsp_done_i = 0; rsp_rrb_i = 0; sts_w1c_i = 0;
  endtask

  task automatic do_reset();
    clear_in();
    rst_ni = 0;
    tick();
    rst_ni = 1;
    tick();
  endtask

  task automatic term(input logic [2:0] k, input logic [7:0] rem);
    clear_in();
    term_vld_i = 1; term_kind_i = k; term_remain_i = rem;
    tick();
    term_vld_i = 0;
  endtask

  task automatic grant_read();
    clear_in();
    eng_idle_i = 1; rd_req_i = 1; rd_burst_i = 8'd4;
    #1;
    tick();
    clear_in();
  endtask

  task automatic grant_write();
    clear_in();
    eng_idle_i = 1; wr_vld_i = 1; wr_fill_i = 8'd8; wr_burst_i = 8'd8;
    tick();
    clear_in();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // reset state
    check("R2 reset gnt", 32'(gnt_o), 0);
    check("R10 reset fail", 32'(rd_fail_o), 0);
    check("R9 reset dummy", 32'(dummy_o), 0);
    check("R4 reset busy", 32'(rrb_busy_o), 0);

    // R1 R2 R3 table
    for (int v = 0; v < NV; v++) begin
      eng_idle_i = VEC[v][21]; rd_req_i = VEC[v][20]; wr_vld_i = VEC[v][19];
      wr_fill_i = VEC[v][18:11]; wr_burst_i = VEC[v][10:3]; rd_burst_i = 8'd2;
      #1;
      check($sformatf("R1/R3 vec %0d gnt", v), 32'(gnt_o), 32'(VEC[v][2:0]));
      tick();
      clear_in();
      rsp_done_i = 1; rsp_rrb_i = 0;
      tick();
      rsp_done_i = 0;
    end

    // R1 count on write
    eng_idle_i = 1; wr_vld_i = 1; wr_fill_i = 8'd8; wr_burst_i = 8'd12; #1;
    check("R1 write count", 32'(gnt_cnt_o), 12);
    clear_in();

    // R4 R5: fill both buffers
    do_reset();
    eng_idle_i = 1; rd_req_i = 1; rd_burst_i = 8'd4; #1;
    check("R4 first rrb", 32'(gnt_rrb_o), 0);
    check("R1 read count", 32'(gnt_cnt_o), 4);
    tick(); #1;
    check("R4 second grant", 32'(gnt_o), 3'b010);
    check("R4 second rrb", 32'(gnt_rrb_o), 1);
    check("R4 busy after first", 32'(rrb_busy_o), 2'b01);
    tick(); #1;
    check("R4 busy full", 32'(rrb_busy_o), 2'b11);
    check("R4 read stalls", 32'(gnt_o), 0);
    wr_vld_i = 1; wr_fill_i = 8'd8; wr_burst_i = 8'd8; #1;
    check("R4 write passes", 32'(gnt_o), 3'b100);
    wr_vld_i = 0; eng_idle_i = 0;
    rsp_done_i = 1; rsp_rrb_i = 1;
    tick();
    rsp_done_i = 0; eng_idle_i = 1; #1;
    check("R5 busy after release", 32'(rrb_busy_o), 2'b01);
    check("R5 read retakes", 32'(gnt_o), 3'b010);
    check("R5 rrb reused", 32'(gnt_rrb_o), 1);
    clear_in();

    // R6 R8: continuation read with no free buffer
    do_reset();
    grant_read(); grant_read();
    term(3'd2, 8'd3);
    eng_idle_i = 1; rd_req_i = 1; wr_vld_i = 1; wr_fill_i = 8'd8; wr_burst_i = 8'd8; #1;
    check("R6 cont read granted", 32'(gnt_o), 3'b001);
    check("R6 cont count", 32'(gnt_cnt_o), 3);
    check("R6 cont rrb", 32'(gnt_rrb_o), 1);
    tick(); #1;
    check("R6 cont consumed", 32'(gnt_o), 3'b100);
    clear_in();

    // R7 R8: write continuation
    do_reset();
    grant_write();
    term(3'd1, 8'd5);
    eng_idle_i = 1; rd_req_i = 1; wr_vld_i = 1; wr_fill_i = 8'd4; wr_burst_i = 8'd8; #1;
    check("R7 short fill blocks", 32'(gnt_o), 0);
    check("R8 read held", 32'(rrb_busy_o), 0);
    wr_fill_i = 8'd5; #1;
    check("R7 cont write", 32'(gnt_o), 3'b001);
    check("R7 cont count", 32'(gnt_cnt_o), 5);
    tick();
    clear_in();

    // R9 R10
    do_reset();
    grant_read();
    term(3'd4, 8'd2);
    #1;
    check("R9 fail set", 32'(rd_fail_o), 1);
    check("R9 dummy pulse", 32'(dummy_o), 1);
    check("R9 dummy rrb", 32'(dummy_rrb_o), 0);
    check("R9 buffer freed", 32'(rrb_busy_o), 0);
    tick(); #1;
    check("R9 dummy one cycle", 32'(dummy_o), 0);
    check("R10 sticky", 32'(rd_fail_o), 1);
    sts_w1c_i = 1;
    tick(); #1;
    sts_w1c_i = 0;
    check("R10 clear", 32'(rd_fail_o), 0);
    grant_read();
    clear_in();
    term_vld_i = 1; term_kind_i = 3'd3; sts_w1c_i = 1;
    tick(); #1;
    clear_in();
    check("R10 set beats clear", 32'(rd_fail_o), 1);
    sts_w1c_i = 1;
    tick();
    sts_w1c_i = 0;

    // R11 write abort
    grant_write();
    term(3'd3, 8'd4);
    #1;
    check("R11 no fail", 32'(rd_fail_o), 0);
    check("R11 no dummy", 32'(dummy_o), 0);
    eng_idle_i = 1; wr_vld_i = 1; wr_fill_i = 8'd8; wr_burst_i = 8'd8; #1;
    check("R11 next proceeds", 32'(gnt_o), 3'b100);
    clear_in();

    // R12 complete
    do_reset();
    grant_read();
    term(3'd0, 8'd0);
    eng_idle_i = 1; #1;
    check("R12 no cont", 32'(gnt_o), 0);
    check("R12 busy kept", 32'(rrb_busy_o), 2'b01);
    rsp_done_i = 1; rsp_rrb_i = 0;
    tick(); #1;
    check("R12 freed", 32'(rrb_busy_o), 0);
    clear_in();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule